// File: doc/BRIEF.md
# Sign-Injection Unit with Single-Precision Boxing

This unit performs the three single-precision sign-injection operations on values held in a 64-bit floating-point register file. A 32-bit value is stored there inside a "box": its upper 32 bits are all ones. Each 64-bit operand is examined first. A properly boxed operand gives up its low word. Any other operand is replaced by the single-precision canonical quiet NaN. The chosen operation then produces a 32-bit result. That result is boxed again before it goes back to the register file.

A fourth operation moves a 32-bit word into the register file and boxes it. The word can come from the low half of an integer register or from a word load. The result passes through one register stage, so it appears one cycle after the request. The valid flag follows the request with the same delay.

When both operands come from the same register, the three sign operations act as move, negate and absolute value. No extra control is needed for this, because the operand check runs first and the sign rules then reduce to these operations.

Top module: `nbsgn_unit`

## Requirements
- R1: While `rst_n` is low, `res` reads 0 and `res_valid` reads 0, even if `in_valid` is high.
- R2: An operand whose bits 63:32 are all ones is used as the single-precision value held in its bits 31:0.
- R3: An operand with any zero in bits 63:32 is used as the value 0x7FC00000. This includes an upper half that is only partly ones.
- R4: Operation code 2'b00 (copy sign) gives bit 31 from the checked second operand and bits 30:0 from the checked first operand.
- R5: Operation code 2'b01 (inverted copy sign) gives bit 31 equal to the inverse of the checked second operand's bit 31, and bits 30:0 from the checked first operand.
- R6: Operation code 2'b10 (sign XOR) gives bit 31 equal to the XOR of both checked sign bits, and bits 30:0 from the checked first operand.
- R7: With equal operands, codes 00, 01 and 10 give move, negate (bit 31 flipped) and absolute value (bit 31 cleared) of the checked operand. A badly boxed operand therefore gives 0x7FC00000, 0xFFC00000 and 0x7FC00000 in the low word.
- R8: Operation code 2'b11 places the 32-bit `int_word` in bits 31:0 and ignores both floating-point operands.
- R9: Every result written has bits 63:32 all ones, including canonical NaN results.
- R10: A request accepted on a rising edge with `in_valid` high appears on `res` with `res_valid` high after exactly that edge. Back-to-back requests give back-to-back results. `res_valid` is low in the cycle after a cycle with `in_valid` low.
- R11: While `in_valid` is low, `res` holds its last value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request qualifier |
| op_sel | input | 2 | 00 copy sign, 01 inverted copy sign, 10 sign XOR, 11 word move |
| opa | input | 64 | First floating-point operand (magnitude source) |
| opb | input | 64 | Second floating-point operand (sign source) |
| int_word | input | 32 | Word from an integer register low half or a word load |
| res | output | 64 | Registered, boxed result |
| res_valid | output | 1 | Result qualifier, one cycle after `in_valid` |

## Verification
A wrong box decision on an operand shows on the next cycle. Either a real magnitude appears where 0x7FC00000 belongs, or a canonical NaN appears where a value should have passed through. A patterned operand whose upper half is only partly ones separates a full 32-bit compare from a shortcut check. A wrong sign rule or a swapped operand role shows in bit 31 or bits 30:0 in the same next cycle. Equal-operand cases catch a unit that gets the general formula right but the move/negate/absolute reduction wrong. A result register that loads while idle shows as a changed `res` during idle cycles, and a valid flag off by one cycle breaks the ordered scoreboard at its first item.

// File: rtl/nbsgn_pkg.sv
package nbsgn_pkg;

  localparam int SP_W = 32;

  localparam logic [SP_W-1:0] SP_CANON_NAN = 32'h7FC0_0000;

  typedef enum logic [1:0] {
    SGN_COPY = 2'b00,
    SGN_INV  = 2'b01,
    SGN_XOR  = 2'b10,
    SGN_IMOV = 2'b11
  } sgn_op_e;

  // Sign rule: choose the new sign bit from the two checked signs.
  function automatic logic pick_sign(sgn_op_e op, logic sa, logic sb);
    logic s;
    case (op)
      SGN_COPY: s = sb;
      SGN_INV:  s = ~sb;
      SGN_XOR:  s = sa ^ sb;
      default:  s = sa;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nbsgn_unbox.sv
module nbsgn_unbox
  import nbsgn_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [FLEN-1:0] reg_val,
  output logic [SP_W-1:0] sp_val,
  output logic            box_ok
);

  localparam int BOX_W = FLEN - SP_W;

  function automatic logic is_boxed(logic [FLEN-1:0] v);
    return &v[FLEN-1:SP_W];
  endfunction

  always_comb begin
    box_ok = is_boxed(reg_val);
    sp_val = box_ok ? reg_val[SP_W-1:0] : SP_CANON_NAN;
  end

  initial begin
    assert (BOX_W > 0) else $error("box width must be positive");
  end

endmodule

// File: rtl/nbsgn_inject.sv
module nbsgn_inject
  import nbsgn_pkg::*;
(
  input  sgn_op_e         op,
  input  logic [SP_W-1:0] a_sp,
  input  logic [SP_W-1:0] b_sp,
  input  logic [SP_W-1:0] word_in,
  output logic [SP_W-1:0] res_sp
);

  logic new_sign;

  always_comb begin
    new_sign = pick_sign(op, a_sp[SP_W-1], b_sp[SP_W-1]);
    if (op == SGN_IMOV) res_sp = word_in;
    else                res_sp = {new_sign, a_sp[SP_W-2:0]};
  end

endmodule

// File: rtl/nbsgn_boxreg.sv
module nbsgn_boxreg
  import nbsgn_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SP_W-1:0] d_sp,
  output logic [FLEN-1:0] q,
  output logic            q_valid
);

  localparam int BOX_W = FLEN - SP_W;

  function automatic logic [FLEN-1:0] do_box(logic [SP_W-1:0] v);
    return {{BOX_W{1'b1}}, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) q <= do_box(d_sp);
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R11

endmodule

// File: rtl/nbsgn_unit.sv
module nbsgn_unit
  import nbsgn_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      op_sel,
  input  logic [FLEN-1:0] opa,
  input  logic [FLEN-1:0] opb,
  input  logic [SP_W-1:0] int_word,
  output logic [FLEN-1:0] res,
  output logic            res_valid
);

  localparam int NOPS = 2;

  logic [FLEN-1:0] ops_in  [NOPS];
  logic [SP_W-1:0] ops_sp  [NOPS];
  logic            ops_ok  [NOPS];

  assign ops_in[0] = opa;
  assign ops_in[1] = opb;

  generate
    for (genvar g = 0; g < NOPS; g++) begin : g_chk
      nbsgn_unbox #(.FLEN(FLEN)) u_unbox (
        .reg_val (ops_in[g]),
        .sp_val  (ops_sp[g]),
        .box_ok  (ops_ok[g])
      );
    end
  endgenerate

  // Named internal events for the assertions.
  sgn_op_e         op_e;
  logic [SP_W-1:0] a_chk, b_chk, next_sp;
  logic            a_good, b_good;

  assign op_e   = sgn_op_e'(op_sel);
  assign a_chk  = ops_sp[0];
  assign b_chk  = ops_sp[1];
  assign a_good = ops_ok[0];
  assign b_good = ops_ok[1];

  nbsgn_inject u_inject (
    .op      (op_e),
    .a_sp    (a_chk),
    .b_sp    (b_chk),
    .word_in (int_word),
    .res_sp  (next_sp)
  );

  nbsgn_boxreg #(.FLEN(FLEN)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .d_sp    (next_sp),
    .q       (res),
    .q_valid (res_valid)
  );

  AST_GOOD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (opa[FLEN-1:SP_W] == '1) |-> (a_chk == opa[SP_W-1:0])); // R2
  AST_BAD_NAN_A: assert property (@(posedge clk) disable iff (!rst_n)
    !a_good |-> (a_chk == SP_CANON_NAN)); // R3
  AST_BAD_NAN_B: assert property (@(posedge clk) disable iff (!rst_n)
    (opb[FLEN-1:SP_W] != '1) |-> (b_chk == SP_CANON_NAN && !b_good)); // R3
  AST_MAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e != SGN_IMOV) |=> (res[SP_W-2:0] == $past(a_chk[SP_W-2:0]))); // R4
  AST_SIGN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == SGN_COPY) |=> (res[SP_W-1] == $past(b_chk[SP_W-1]))); // R4
  AST_SIGN_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == SGN_INV) |=> (res[SP_W-1] != $past(b_chk[SP_W-1]))); // R5
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == SGN_XOR) |=>
      (res[SP_W-1] == ($past(a_chk[SP_W-1]) ^ $past(b_chk[SP_W-1])))); // R6
  AST_WORD_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == SGN_IMOV) |=> (res[SP_W-1:0] == $past(int_word))); // R8
  AST_OUT_BOXED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res[FLEN-1:SP_W] == '1)); // R9
  AST_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid); // R10
  AST_VALID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid); // R10

endmodule

// File: tb/nbsgn_unit_tb_top.sv
`timescale 1ns/1ps
module nbsgn_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic [31:0] int_word = '0;
  logic [63:0] res;
  logic        res_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t sb[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  nbsgn_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opa(opa), .opb(opb), .int_word(int_word), .res(res), .res_valid(res_valid)
  );

  // Reference model written from the requirements.
  function automatic logic [31:0] ref_unbox(logic [63:0] x);
    if (x >= 64'hFFFF_FFFF_0000_0000) return x[31:0];
    return 32'h7FC0_0000;
  endfunction

  function automatic logic [63:0] ref_op(logic [1:0] op, logic [63:0] a,
                                         logic [63:0] b, logic [31:0] w);
    logic [31:0] av, bv, r;
    av = ref_unbox(a);
    bv = ref_unbox(b);
    r = av;
    if (op == 2'd0) r[31] = bv[31];
    else if (op == 2'd1) r[31] = !bv[31];
    else if (op == 2'd2) r[31] = (av[31] != bv[31]);
    else r = w;
    return {32'hFFFF_FFFF, r};
  endfunction

  function automatic logic [63:0] bx(logic [31:0] v);
    return {32'hFFFF_FFFF, v};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [63:0] a, logic [63:0] b,
                      logic [31:0] w, string tag);
    item_t it;
    @(negedge clk);
    op_sel = op; opa = a; opb = b; int_word = w; in_valid = 1'b1;
    it.exp = ref_op(op, a, b, w);
    it.due = cyc + 1;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " R10 valid"}, {63'd0, res_valid}, 64'd1);
        check(it.tag, res, it.exp);
      end else if (res_valid) begin
        check("R10 unexpected valid", {63'd0, res_valid}, 64'd0);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rb, last;
    logic [31:0] rw;
    // R1: reset state, request ignored while in reset
    in_valid = 1'b1; op_sel = 2'b11; int_word = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R1 res in reset", res, 64'd0);
    check("R1 valid in reset", {63'd0, res_valid}, 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 res after reset", res, 64'd0);

    // R2, R4, R5, R6 with good boxes
    send(2'd0, bx(32'h3F80_0000), bx(32'hC000_0000), 0, "R4 copy neg");
    send(2'd1, bx(32'h3F80_0000), bx(32'hC000_0000), 0, "R5 inv");
    send(2'd2, bx(32'hBF80_0000), bx(32'hC000_0000), 0, "R6 xor both neg");
    send(2'd2, bx(32'h3F80_0000), bx(32'hC000_0000), 0, "R6 xor mixed");
    send(2'd0, bx(32'hC123_4567), bx(32'h0000_0001), 0, "R2 R4 copy pos");
    // R3 bad boxes
    send(2'd0, 64'h0000_0000_3F80_0000, bx(32'h8000_0000), 0, "R3 bad a zero top");
    send(2'd0, 64'hFFFF_FFFE_3F80_0000, bx(32'h0000_0000), 0, "R3 bad a partial");
    send(2'd0, bx(32'h4000_0000), 64'h7FFF_FFFF_FFFF_FFFF, 0, "R3 bad b sign");
    send(2'd1, bx(32'h4000_0000), 64'hFFFF_0000_8000_0000, 0, "R3 bad b inv");
    // R7 equal operands
    send(2'd0, bx(32'hC049_0FDB), bx(32'hC049_0FDB), 0, "R7 move");
    send(2'd1, bx(32'hC049_0FDB), bx(32'hC049_0FDB), 0, "R7 negate");
    send(2'd2, bx(32'hC049_0FDB), bx(32'hC049_0FDB), 0, "R7 abs");
    send(2'd0, 64'h1, 64'h1, 0, "R7 R9 move bad box");
    send(2'd1, 64'h1, 64'h1, 0, "R7 R9 negate bad box");
    send(2'd2, 64'h1, 64'h1, 0, "R7 R9 abs bad box");
    // R8 word move, float operands ignored
    send(2'd3, 64'h0, 64'h0, 32'h8000_0001, "R8 move word");
    send(2'd3, bx(32'hFFFF_FFFF), 64'h5, 32'h0000_0000, "R8 R9 move zero");
    // mixed stream
    ra = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 40; i++) begin
      ra = ra ^ (ra << 13); ra = ra ^ (ra >> 7); ra = ra ^ (ra << 17);
      rb = {ra[31:0], ra[63:32]};
      rw = ra[47:16];
      send(ra[1:0], (i % 3 == 0) ? ra : bx(ra[31:0]),
           (i % 4 == 1) ? rb : bx(rb[31:0]), rw, "R9 R10 stream");
    end
    // R11 hold while idle
    send(2'd1, bx(32'h0ABC_DEF0), bx(32'h0000_0000), 0, "R11 setup");
    last = ref_op(2'd1, bx(32'h0ABC_DEF0), bx(32'h0000_0000), 0);
    @(negedge clk);
    in_valid = 1'b0; op_sel = 2'b11; int_word = 32'hDEAD_BEEF;
    opa = 64'h0; opb = 64'h0;
    @(negedge clk);
    check("R11 hold 1", res, last);
    @(negedge clk);
    check("R11 hold 2", res, last);
    check("R10 idle valid low", {63'd0, res_valid}, 64'd0);
    idle();
    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", 64'(sb.size()), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule